// File: doc/BRIEF.md
# Pulse-Driven Trim Programming Controller

This block turns two kinds of pulse events, medium and high, into writes of on-chip trim values and into requests to burn single fuse bits. A pulse decoder outside the block reports each detected pulse as a one-cycle strobe. The controller walks through a fixed sequence: a high pulse wakes it, a counted run of medium pulses picks the mode, and two high pulses move on to register selection. There a counted run of medium pulses, the key, picks one of five trim registers, and a high pulse starts addressing. In addressing, each medium pulse raises the register code by one.

Two modes are offered. In trial mode a high pulse during addressing goes back to register selection, so several trims can be adjusted in one supply session; the values stay until the next reset. In burn mode a high pulse during addressing asks for the single addressed fuse bit to be burned, and the controller then ignores all pulses until the next reset. A reset stands for a power cycle. At reset every register loads its burned fuse bits, so bits burned in earlier sessions are combined with later ones. A burned lock bit freezes all programming. The fuse array itself is outside the block and is presented as input vectors.

Top module: `trim_prog_top`

## Requirements
- R1: While reset is held, each trim output takes its fuse input value and the error flag is 0. After reset the controller waits for a high pulse, and medium pulses that arrive while it waits have no effect on the trims or on later key counts.
- R2: From the waiting state, a high pulse opens mode selection. There, 1 medium pulse picks burn mode and 2 medium pulses pick trial mode, and the next high pulse closes the choice. Any other count sets the error flag. After a valid choice, one more high pulse opens register selection.
- R3: In register selection, the key is the number of medium pulses, and a high pulse confirms it. Key 1 is the sensitivity register (9 bits), key 2 the duty register (9 bits), key 3 the carrier register (5 bits: a coarse bit of weight 16 over 4 fine bits), key 4 is an empty register that has no bits, and key 5 is the control register (10 bits).
- R4: During addressing, each medium pulse raises the register code by one, starting from 0 on entry. The chosen register then reads its value at entry OR the code, one cycle after the pulse.
- R5: The code saturates at 2^W-1, where W is the width of the chosen register. For the empty register the code stays at 0.
- R6: In trial mode, a high pulse during addressing returns to register selection with a new key count, and every register keeps the value it was given.
- R7: In burn mode, when a high pulse arrives during addressing and the code has exactly one bit set, a one-cycle burn strobe follows in the next cycle. The strobe carries the register key and the index of the set bit. After that the controller ignores every pulse until reset, and at most one strobe is issued per reset.
- R8: In burn mode, when a high pulse arrives during addressing and the code is 0 or has more than one bit set, a one-cycle reject strobe is issued instead, with no burn strobe. The controller is then terminal in the same way as in R7.
- R9: Trial values are lost at reset. Burned bits return at every reset and are ORed with codes addressed later.
- R10: When control-register fuse bit 9 is set at reset, the lock output is 1 and all pulses are ignored, so the trims stay at their fuse values.
- R11: The calibration enable output follows control register bit 4.
- R12: A confirmed key of 0 or above 5 sets the error flag. The flag stays set and all pulses are ignored until reset.
- R13: When a high and a medium pulse arrive in the same cycle, the high pulse acts and the medium pulse is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, standing for a power cycle |
| mid_pulse_i | input | 1 | One-cycle strobe for a medium pulse |
| high_pulse_i | input | 1 | One-cycle strobe for a high pulse |
| fuse_sens_i | input | 9 | Burned fuse bits of the sensitivity register |
| fuse_duty_i | input | 9 | Burned fuse bits of the duty register |
| fuse_freq_i | input | 5 | Burned fuse bits of the carrier register |
| fuse_ctl_i | input | 10 | Burned fuse bits of the control register |
| trim_sens_o | output | 9 | Sensitivity trim value |
| trim_duty_o | output | 9 | Duty trim value |
| trim_freq_o | output | 5 | Carrier trim value |
| trim_ctl_o | output | 10 | Control register value |
| cal_en_o | output | 1 | Calibration enable (control bit 4) |
| locked_o | output | 1 | Programming lock captured at reset |
| blow_strobe_o | output | 1 | One-cycle fuse burn request |
| blow_key_o | output | 3 | Register key of the burn request |
| blow_bit_o | output | 4 | Bit index of the burn request |
| blow_reject_o | output | 1 | One-cycle flag for a rejected burn |
| prog_error_o | output | 1 | Sticky flag for an invalid selection key |

## Verification
The checker enforces several rules on every cycle:
- burn and reject are never raised together;
- a burn strobe, or the error flag rising, only ever follows a high pulse;
- the error flag stays set once raised;
- trims change only while addressing is active, and never while locked;
- at most one burn occurs per reset.

Other results need a sequence of pulses, and only the bench scenarios can show them. These are the exact trim values after counted pulse runs, saturation at each register width, and the key-to-register mapping. The bench also covers OR-combination with fuses burned in earlier sessions, rejection of zero or multi-bit codes, and calibration and lock taking effect after a later reset.

// File: rtl/trim_prog_pkg.sv
package trim_prog_pkg;

  localparam int NREG = 5;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_MODE,
    ST_MODE_END,
    ST_REG,
    ST_ADDR,
    ST_SPENT,
    ST_FAULT
  } prog_state_e;

  typedef enum logic [1:0] {
    MODE_NONE,
    MODE_BURN,
    MODE_TRIAL
  } prog_mode_e;

  // width of register slot idx (0-based); slot 3 is the empty register
  function automatic int reg_width(int idx, int w1, int w2, int w3, int w5);
    case (idx)
      0:       return w1;
      1:       return w2;
      2:       return w3;
      4:       return w5;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] code_limit(int w);
    return (32'd1 << w) - 32'd1;
  endfunction

  function automatic logic single_bit(logic [31:0] v);
    return (v != 32'd0) && ((v & (v - 32'd1)) == 32'd0);
  endfunction

  function automatic logic [4:0] bit_index(logic [31:0] v);
    logic [4:0] idx;
    idx = '0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) idx = 5'(i);
    end
    return idx;
  endfunction

endpackage

// File: rtl/trim_key_counter.sv
module trim_key_counter #(
  parameter int KEY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [KEY_W-1:0] count_o
);

  localparam logic [KEY_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      count_o <= '0;
    end else if (step_i && count_o != TOP) begin
      count_o <= count_o + 1'b1;
    end
  end

endmodule

// File: rtl/trim_reg_bank.sv
module trim_reg_bank
  import trim_prog_pkg::*;
#(
  parameter int W1    = 9,
  parameter int W2    = 9,
  parameter int W3    = 5,
  parameter int W5    = 10,
  parameter int MAXW  = 10,
  parameter int KEY_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NREG-1:0][MAXW-1:0]  fuse_i,
  input  logic                       wr_en_i,
  input  logic [KEY_W-1:0]           wr_key_i,
  input  logic [MAXW-1:0]            wr_val_i,
  output logic [NREG-1:0][MAXW-1:0]  val_o
);

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    localparam int              SW   = reg_width(g, W1, W2, W3, W5);
    localparam logic [MAXW-1:0] MASK = MAXW'(code_limit(SW));
    logic [MAXW-1:0] slot_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q <= fuse_i[g] & MASK;
      end else if (wr_en_i && wr_key_i == KEY_W'(g + 1)) begin
        slot_q <= wr_val_i & MASK;
      end
    end

    assign val_o[g] = slot_q;
  end

endmodule

// File: rtl/trim_prog_fsm.sv
module trim_prog_fsm
  import trim_prog_pkg::*;
#(
  parameter int W1    = 9,
  parameter int W2    = 9,
  parameter int W3    = 5,
  parameter int W5    = 10,
  parameter int MAXW  = 10,
  parameter int KEY_W = 3,
  parameter int BW    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mid_i,
  input  logic                      high_i,
  input  logic                      locked_i,
  input  logic [KEY_W-1:0]          key_cnt_i,
  input  logic [NREG-1:0][MAXW-1:0] reg_vals_i,
  output logic                      key_clear_o,
  output logic                      key_step_o,
  output logic                      wr_en_o,
  output logic [KEY_W-1:0]          wr_key_o,
  output logic [MAXW-1:0]           wr_val_o,
  output logic                      blow_strobe_o,
  output logic [KEY_W-1:0]          blow_key_o,
  output logic [BW-1:0]             blow_bit_o,
  output logic                      reject_o,
  output logic                      fault_o,
  output logic                      addr_active_o
);

  prog_state_e     state_q, state_d;
  prog_mode_e      mode_q, mode_d;
  logic [KEY_W-1:0] sel_q, sel_d;
  logic [MAXW-1:0] code_q, code_d;
  logic [MAXW-1:0] base_q, base_d;
  logic            burn_d, rej_d;

  // named events: high wins over medium, both gated by lock
  logic ev_high, ev_mid;
  assign ev_high = high_i && !locked_i;
  assign ev_mid  = mid_i && !high_i && !locked_i;

  logic [MAXW-1:0] sel_limit;
  logic [MAXW-1:0] code_next;
  logic [MAXW-1:0] entry_val;
  logic            key_valid;

  always_comb begin
    sel_limit = MAXW'(code_limit(reg_width(int'(sel_q) - 1, W1, W2, W3, W5)));
    code_next = (code_q == sel_limit) ? code_q : code_q + 1'b1;
    entry_val = '0;
    for (int i = 0; i < NREG; i++) begin
      if (key_cnt_i == KEY_W'(i + 1)) entry_val = reg_vals_i[i];
    end
    key_valid = (key_cnt_i != '0) && (int'(key_cnt_i) <= NREG);
  end

  always_comb begin
    state_d     = state_q;
    mode_d      = mode_q;
    sel_d       = sel_q;
    code_d      = code_q;
    base_d      = base_q;
    key_clear_o = 1'b0;
    key_step_o  = 1'b0;
    wr_en_o     = 1'b0;
    wr_key_o    = sel_q;
    wr_val_o    = base_q | code_next;
    burn_d      = 1'b0;
    rej_d       = 1'b0;
    case (state_q)
      ST_WAIT: begin
        if (ev_high) begin
          state_d     = ST_MODE;
          key_clear_o = 1'b1;
        end
      end
      ST_MODE: begin
        if (ev_high) begin
          if (key_cnt_i == KEY_W'(1)) begin
            mode_d  = MODE_BURN;
            state_d = ST_MODE_END;
          end else if (key_cnt_i == KEY_W'(2)) begin
            mode_d  = MODE_TRIAL;
            state_d = ST_MODE_END;
          end else begin
            state_d = ST_FAULT;
          end
        end else if (ev_mid) begin
          key_step_o = 1'b1;
        end
      end
      ST_MODE_END: begin
        if (ev_high) begin
          state_d     = ST_REG;
          key_clear_o = 1'b1;
        end
      end
      ST_REG: begin
        if (ev_high) begin
          if (key_valid) begin
            state_d = ST_ADDR;
            sel_d   = key_cnt_i;
            code_d  = '0;
            base_d  = entry_val;
          end else begin
            state_d = ST_FAULT;
          end
        end else if (ev_mid) begin
          key_step_o = 1'b1;
        end
      end
      ST_ADDR: begin
        if (ev_high) begin
          if (mode_q == MODE_TRIAL) begin
            state_d     = ST_REG;
            key_clear_o = 1'b1;
          end else begin
            state_d = ST_SPENT;
            if (single_bit(32'(code_q))) burn_d = 1'b1;
            else                         rej_d  = 1'b1;
          end
        end else if (ev_mid) begin
          code_d  = code_next;
          wr_en_o = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= ST_WAIT;
      mode_q        <= MODE_NONE;
      sel_q         <= '0;
      code_q        <= '0;
      base_q        <= '0;
      blow_strobe_o <= 1'b0;
      blow_key_o    <= '0;
      blow_bit_o    <= '0;
      reject_o      <= 1'b0;
    end else begin
      state_q       <= state_d;
      mode_q        <= mode_d;
      sel_q         <= sel_d;
      code_q        <= code_d;
      base_q        <= base_d;
      blow_strobe_o <= burn_d;
      reject_o      <= rej_d;
      if (burn_d) begin
        blow_key_o <= sel_q;
        blow_bit_o <= BW'(bit_index(32'(code_q)));
      end
    end
  end

  assign fault_o       = (state_q == ST_FAULT);
  assign addr_active_o = (state_q == ST_ADDR);

endmodule

// File: rtl/trim_prog_top.sv
module trim_prog_top
  import trim_prog_pkg::*;
#(
  parameter int W1       = 9,
  parameter int W2       = 9,
  parameter int W3       = 5,
  parameter int W5       = 10,
  parameter int KEY_W    = 3,
  parameter int LOCK_BIT = 9,
  parameter int CAL_BIT  = 4,
  parameter int MAXW     = (W1 > W2 ? (W1 > W3 ? (W1 > W5 ? W1 : W5) : (W3 > W5 ? W3 : W5))
                                    : (W2 > W3 ? (W2 > W5 ? W2 : W5) : (W3 > W5 ? W3 : W5))),
  parameter int BW       = $clog2(MAXW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mid_pulse_i,
  input  logic             high_pulse_i,
  input  logic [W1-1:0]    fuse_sens_i,
  input  logic [W2-1:0]    fuse_duty_i,
  input  logic [W3-1:0]    fuse_freq_i,
  input  logic [W5-1:0]    fuse_ctl_i,
  output logic [W1-1:0]    trim_sens_o,
  output logic [W2-1:0]    trim_duty_o,
  output logic [W3-1:0]    trim_freq_o,
  output logic [W5-1:0]    trim_ctl_o,
  output logic             cal_en_o,
  output logic             locked_o,
  output logic             blow_strobe_o,
  output logic [KEY_W-1:0] blow_key_o,
  output logic [BW-1:0]    blow_bit_o,
  output logic             blow_reject_o,
  output logic             prog_error_o
);

  logic [NREG-1:0][MAXW-1:0] fuse_arr;
  logic [NREG-1:0][MAXW-1:0] vals;
  logic [KEY_W-1:0]          key_cnt;
  logic                      key_clear, key_step;
  logic                      wr_en;
  logic [KEY_W-1:0]          wr_key;
  logic [MAXW-1:0]           wr_val;
  logic                      addr_active;
  logic                      lock_q;
  logic                      bank_unused;

  assign fuse_arr[0] = MAXW'(fuse_sens_i);
  assign fuse_arr[1] = MAXW'(fuse_duty_i);
  assign fuse_arr[2] = MAXW'(fuse_freq_i);
  assign fuse_arr[3] = '0;
  assign fuse_arr[4] = MAXW'(fuse_ctl_i);

  // lock is taken from the fuse only, never from a trial value
  always_ff @(posedge clk) begin
    if (!rst_n) lock_q <= fuse_ctl_i[LOCK_BIT];
  end

  trim_key_counter #(.KEY_W(KEY_W)) key_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (key_clear),
    .step_i  (key_step),
    .count_o (key_cnt)
  );

  trim_reg_bank #(
    .W1(W1), .W2(W2), .W3(W3), .W5(W5), .MAXW(MAXW), .KEY_W(KEY_W)
  ) bank_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .fuse_i   (fuse_arr),
    .wr_en_i  (wr_en),
    .wr_key_i (wr_key),
    .wr_val_i (wr_val),
    .val_o    (vals)
  );

  trim_prog_fsm #(
    .W1(W1), .W2(W2), .W3(W3), .W5(W5), .MAXW(MAXW), .KEY_W(KEY_W), .BW(BW)
  ) fsm_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .mid_i         (mid_pulse_i),
    .high_i        (high_pulse_i),
    .locked_i      (lock_q),
    .key_cnt_i     (key_cnt),
    .reg_vals_i    (vals),
    .key_clear_o   (key_clear),
    .key_step_o    (key_step),
    .wr_en_o       (wr_en),
    .wr_key_o      (wr_key),
    .wr_val_o      (wr_val),
    .blow_strobe_o (blow_strobe_o),
    .blow_key_o    (blow_key_o),
    .blow_bit_o    (blow_bit_o),
    .reject_o      (blow_reject_o),
    .fault_o       (prog_error_o),
    .addr_active_o (addr_active)
  );

  assign trim_sens_o = vals[0][W1-1:0];
  assign trim_duty_o = vals[1][W2-1:0];
  assign trim_freq_o = vals[2][W3-1:0];
  assign trim_ctl_o  = vals[4][W5-1:0];
  assign cal_en_o    = vals[4][CAL_BIT];
  assign locked_o    = lock_q;
  assign bank_unused = ^vals;

endmodule

// File: rtl/trim_prog_checker.sv
module trim_prog_checker #(
  parameter int W1 = 9,
  parameter int W2 = 9,
  parameter int W3 = 5,
  parameter int W5 = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          high_pulse_i,
  input logic          blow_strobe_o,
  input logic          blow_reject_o,
  input logic          prog_error_o,
  input logic          locked_o,
  input logic          addr_active,
  input logic [W1-1:0] trim_sens_o,
  input logic [W2-1:0] trim_duty_o,
  input logic [W3-1:0] trim_freq_o,
  input logic [W5-1:0] trim_ctl_o
);

  logic [1:0] burns_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burns_seen <= '0;
    end else begin
      if (blow_strobe_o && burns_seen != 2'd3) burns_seen <= burns_seen + 1'b1;
      assert_one_burn_R7: assert (burns_seen <= 2'd1);
    end
  end

  assert_single_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(blow_strobe_o && blow_reject_o));

  assert_burn_after_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blow_strobe_o |-> $past(high_pulse_i));

  assert_error_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    prog_error_o |=> prog_error_o);

  assert_error_on_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_error_o) |-> $past(high_pulse_i));

  assert_trim_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_active |=> ($stable(trim_sens_o) && $stable(trim_duty_o)
                      && $stable(trim_freq_o) && $stable(trim_ctl_o)));

  assert_lock_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |-> !addr_active && !blow_strobe_o && !blow_reject_o);

endmodule

bind trim_prog_top trim_prog_checker #(.W1(W1), .W2(W2), .W3(W3), .W5(W5)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .high_pulse_i  (high_pulse_i),
  .blow_strobe_o (blow_strobe_o),
  .blow_reject_o (blow_reject_o),
  .prog_error_o  (prog_error_o),
  .locked_o      (locked_o),
  .addr_active   (addr_active),
  .trim_sens_o   (trim_sens_o),
  .trim_duty_o   (trim_duty_o),
  .trim_freq_o   (trim_freq_o),
  .trim_ctl_o    (trim_ctl_o)
);

// File: tb/trim_prog_top_tb_top.sv
module trim_prog_top_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mid = 1'b0;
  logic high = 1'b0;
  logic [8:0] fz_sens = '0;
  logic [8:0] fz_duty = '0;
  logic [4:0] fz_freq = '0;
  logic [9:0] fz_ctl = '0;
  logic [8:0] t_sens, t_duty;
  logic [4:0] t_freq;
  logic [9:0] t_ctl;
  logic       cal_en, locked, burn, rej, err;
  logic [2:0] b_key;
  logic [3:0] b_bit;

  int checks = 0;
  int errors = 0;
  int n_burn = 0;
  int n_rej = 0;
  int last_key = 0;
  int last_bit = 0;

  always #5 clk = ~clk;

  trim_prog_top dut_i (
    .clk (clk), .rst_n (rst_n), .mid_pulse_i (mid), .high_pulse_i (high),
    .fuse_sens_i (fz_sens), .fuse_duty_i (fz_duty), .fuse_freq_i (fz_freq),
    .fuse_ctl_i (fz_ctl), .trim_sens_o (t_sens), .trim_duty_o (t_duty),
    .trim_freq_o (t_freq), .trim_ctl_o (t_ctl), .cal_en_o (cal_en),
    .locked_o (locked), .blow_strobe_o (burn), .blow_key_o (b_key),
    .blow_bit_o (b_bit), .blow_reject_o (rej), .prog_error_o (err)
  );

  // fuse array model and strobe monitor
  always @(negedge clk) begin
    if (rst_n && burn) begin
      n_burn++;
      last_key = int'(b_key);
      last_bit = int'(b_bit);
      case (b_key)
        3'd1: fz_sens[b_bit] = 1'b1;
        3'd2: fz_duty[b_bit] = 1'b1;
        3'd3: fz_freq[b_bit] = 1'b1;
        3'd5: fz_ctl[b_bit]  = 1'b1;
        default: ;
      endcase
    end
    if (rst_n && rej) n_rej++;
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 1'b0; mid = 1'b0; high = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic hp();
    @(negedge clk) high = 1'b1;
    @(negedge clk) high = 1'b0;
  endtask

  task automatic mp(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) mid = 1'b1;
      @(negedge clk) mid = 1'b0;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter(int mode_cnt, int key);
    hp(); mp(mode_cnt); hp(); hp(); mp(key); hp();
  endtask

  function automatic int width_of(int k);
    case (k)
      1: return 9;
      2: return 9;
      3: return 5;
      5: return 10;
      default: return 0;
    endcase
  endfunction

  function automatic int trim_of(int k);
    case (k)
      1: return int'(t_sens);
      2: return int'(t_duty);
      3: return int'(t_freq);
      5: return int'(t_ctl);
      default: return 0;
    endcase
  endfunction

  function automatic int trim_sum();
    return int'(t_sens) + int'(t_duty) + int'(t_freq) + int'(t_ctl);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lim;
    // R1 reset state
    reset_dut();
    check("R1 reset trims", trim_sum(), 0);
    check("R1 reset error", int'(err), 0);
    check("R10 reset lock", int'(locked), 0);

    // R1 mediums ignored while waiting; R2 trial selection works after
    mp(3);
    check("R1 idle mediums", trim_sum(), 0);
    enter(2, 1); mp(2);
    check("R1 R2 trial after idle mediums", int'(t_sens), 2);
    check("R2 no error", int'(err), 0);

    // R3 R4 R5 sweep each register in trial mode
    for (int k = 1; k <= 5; k++) begin
      reset_dut();
      enter(2, k);
      lim = (1 << width_of(k)) - 1;
      for (int n = 1; n <= lim + 2; n++) begin
        mp(1);
        if (k == 4) check("R5 empty register", trim_sum(), 0);
        else if (n <= 3 || n >= lim)
          check($sformatf("R4 R5 key%0d n%0d", k, n), trim_of(k), (n > lim) ? lim : n);
      end
      check($sformatf("R3 key%0d others", k), trim_sum() - trim_of(k), 0);
    end

    // R6 trial loop keeps values; R4 entry OR code; R9 reset clears
    reset_dut();
    enter(2, 2); mp(7);
    hp(); mp(3); hp(); mp(4);
    check("R6 duty kept", int'(t_duty), 7);
    check("R6 freq set", int'(t_freq), 4);
    hp(); mp(2); hp(); mp(1);
    check("R4 entry OR code", int'(t_duty), 7);
    reset_dut();
    check("R9 trial cleared", trim_sum(), 0);

    // R2 bad mode count
    reset_dut();
    hp(); mp(3); hp();
    check("R2 bad mode error", int'(err), 1);
    hp(); mp(2); hp(); mp(1);
    check("R12 error ignores pulses", trim_sum(), 0);
    check("R12 error sticky", int'(err), 1);

    // R12 bad keys 6 and 0
    reset_dut();
    enter(2, 6);
    check("R12 key6 error", int'(err), 1);
    mp(3); hp(); mp(2);
    check("R12 key6 trims", trim_sum(), 0);
    reset_dut();
    check("R12 reset clears error", int'(err), 0);
    hp(); mp(2); hp(); hp(); hp();
    check("R12 key0 error", int'(err), 1);

    // R8 rejects: multi-bit, zero, empty register
    reset_dut();
    enter(1, 2); mp(3); hp(); idle(2);
    check("R8 multibit reject", n_rej, 1);
    check("R8 no burn", n_burn, 0);
    reset_dut();
    enter(1, 2); hp(); idle(2);
    check("R8 zero reject", n_rej, 2);
    reset_dut();
    enter(1, 4); mp(5); hp(); idle(2);
    check("R8 empty reject", n_rej, 3);
    check("R8 still no burn", n_burn, 0);

    // R13 high and medium together
    reset_dut();
    @(negedge clk) begin high = 1'b1; mid = 1'b1; end
    @(negedge clk) begin high = 1'b0; mid = 1'b0; end
    mp(2); hp(); hp(); mp(1); hp(); mp(1);
    check("R13 high wins", int'(t_sens), 1);
    check("R13 no error", int'(err), 0);

    // R7 burn one bit, then terminal
    reset_dut();
    enter(1, 1); mp(4); hp(); idle(2);
    check("R7 one burn", n_burn, 1);
    check("R7 burn key", last_key, 1);
    check("R7 burn bit", last_bit, 2);
    hp(); mp(3); hp(); hp(); mp(1); hp(); mp(2); hp(); idle(2);
    check("R7 terminal burns", n_burn, 1);
    check("R7 terminal trim", int'(t_sens), 4);
    reset_dut();
    check("R9 fuse restored", int'(t_sens), 4);
    enter(1, 1); mp(1); hp(); idle(2);
    check("R7 second burn bit", last_bit, 0);
    reset_dut();
    check("R9 fuse OR", int'(t_sens), 5);
    enter(2, 1); mp(2);
    check("R9 trial over fuse", int'(t_sens), 7);
    reset_dut();
    check("R9 trial dropped", int'(t_sens), 5);

    // R11 calibration bit
    enter(1, 5); mp(16); hp(); idle(2);
    check("R11 burn bit4", last_bit, 4);
    reset_dut();
    check("R11 cal enable", int'(cal_en), 1);
    check("R11 ctl value", int'(t_ctl), 16);

    // R10 lock bit
    enter(1, 5); mp(512); hp(); idle(2);
    check("R10 burn bit9", last_bit, 9);
    reset_dut();
    check("R10 locked", int'(locked), 1);
    enter(2, 1); mp(3); hp(); idle(2);
    check("R10 locked sens", int'(t_sens), int'(fz_sens));
    check("R10 locked ctl", int'(t_ctl), 528);
    check("R10 locked no burn", n_burn, 4);
    check("R10 locked no error", int'(err), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule